// File: doc/BRIEF.md
# Dual-Path Storing Bus Transceiver

The block sits between two shared tri-state buses, side A and side B, each `WIDTH` bits wide with a default of 18. Each direction has its own storage element and its own three controls: a pass control, a strobe and an output enable. While its pass control is high, a direction's storage is transparent and follows the source bus. While pass is low, a rising strobe loads the source bus into storage. Between rising strobes, storage keeps its value.

The output enable decides whether the stored value is placed on the far bus or whether that bus is released to high impedance. The enable for A-to-B is active high. The enable for B-to-A is active low.

All state is clocked by one system clock `clk` with a synchronous active-high reset. The two strobes are treated as level inputs and sampled on `clk`. A strobe rise is detected when the strobe reads high at a `clk` edge and read low at the edge before. The source bus is captured at the edge where the rise is detected, and the stored value appears on the outputs from that edge on. Transparency needs no clock edge: while pass is high, the output follows the source bus combinationally.

Top module: `dual_path_xcvr`

## Requirements
- R1: While `ab_pass` is 1 and `ab_drive` is 1, `port_b` equals the present value of `port_a`. Storage reloads from `port_a` on every `clk` edge during that time.
- R2: While `ab_pass` is 0, a strobe rise loads storage with the value `port_a` holds at that `clk` edge. A strobe rise means `ab_strobe` reads 1 at a `clk` edge after reading 0 at the previous edge. From that edge on, `port_b` shows the loaded value.
- R3: While `ab_pass` is 0 and `ab_strobe` does not rise, storage does not change. This covers `ab_strobe` held at 1, held at 0, and falling from 1 to 0, whatever `port_a` does.
- R4: `port_b` is driven from the A-to-B path only while `ab_drive` is 1. While `ab_drive` is 0, the block leaves `port_b` at high impedance, so a value placed on `port_b` from outside reads back unchanged.
- R5: The B-to-A path behaves as R1 to R3 describe, with `ba_pass` and `ba_strobe` controlling it, `port_b` as its source and `port_a` as its destination.
- R6: `ba_drive_n` is active low. `port_a` is driven from B-to-A storage while `ba_drive_n` is 0 and left at high impedance while it is 1.
- R7: When `ab_pass` or `ba_pass` falls from 1 to 0, storage keeps the source value taken at the last `clk` edge at which pass was 1.
- R8: The two directions have separate storage. Both can hold different values at once, and each bus carries its own path's value when both enables are asserted.
- R9: A `clk` edge with `rst` at 1 clears both storages to all zeros. It also marks both strobes as if they had last read 1, so a strobe already high when reset is released does not count as a rise.
- R10: Both buses are `WIDTH` bits wide, with `WIDTH` defaulting to 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the strobes and updates storage |
| rst | input | 1 | Synchronous active-high reset |
| ab_pass | input | 1 | A-to-B pass control: 1 makes storage transparent |
| ab_strobe | input | 1 | A-to-B load strobe, acts on its rise while pass is 0 |
| ab_drive | input | 1 | A-to-B output enable, active high |
| ba_pass | input | 1 | B-to-A pass control: 1 makes storage transparent |
| ba_strobe | input | 1 | B-to-A load strobe, acts on its rise while pass is 0 |
| ba_drive_n | input | 1 | B-to-A output enable, active low |
| port_a | inout | WIDTH | Bus A: source for A-to-B, destination for B-to-A |
| port_b | inout | WIDTH | Bus B: source for B-to-A, destination for A-to-B |

## Verification
A single `clk` edge can carry both a strobe rise and a fall of the pass control. In that case the design must load the source bus at that edge, and no transparency may leak into the next cycle. Likewise, a change on the source bus in the same cycle as a strobe that only falls or stays high must leave storage unchanged. The bench provokes these cases by changing the source data at the same negative edge where it moves the strobe or the pass control. It then judges the result on the destination bus one `clk` edge later, comparing against the value the source held at the edge of the rise.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned XCVR_WIDTH = 18;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_FOLLOW  = 2'd1,
        ST_CAPTURE = 2'd2
    } store_op_e;

    typedef struct packed {
        logic pass;
        logic strobe;
        logic drive;
    } lane_ctrl_t;

    // Pass has priority over the strobe; a rise only matters while pass is low.
    function automatic store_op_e pick_op(input logic pass, input logic rise);
        if (pass)
            return ST_FOLLOW;
        else if (rise)
            return ST_CAPTURE;
        return ST_HOLD;
    endfunction

    function automatic logic drive_active(input logic level, input logic active_low);
        return active_low ? ~level : level;
    endfunction

endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic last_q;

    // Reset value 1: a strobe already high at reset release is not a rise.
    always_ff @(posedge clk) begin
        if (rst)
            last_q <= 1'b1;
        else
            last_q <= level;
    end

    assign rise = level & ~last_q & ~rst;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = XCVR_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  store_op_e        op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else begin
            case (op)
                ST_FOLLOW,
                ST_CAPTURE: held_q <= din;
                default:    held_q <= held_q;
            endcase
        end
    end

    // Transparent view while following; stored value otherwise.
    assign dout = (op == ST_FOLLOW) ? din : held_q;
endmodule

// File: rtl/xcvr_oe_drive.sv
module xcvr_oe_drive #(
    parameter int unsigned WIDTH = 18
) (
    input  logic             en,
    input  logic [WIDTH-1:0] val,
    inout  wire  [WIDTH-1:0] pad
);
    assign pad = en ? val : {WIDTH{1'bz}};
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH         = XCVR_WIDTH,
    parameter bit          OE_ACTIVE_LOW = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  lane_ctrl_t       ctrl,
    input  logic [WIDTH-1:0] src,
    inout  wire  [WIDTH-1:0] dst
);
    logic             rise;
    store_op_e        op;
    logic [WIDTH-1:0] stored;
    logic             oe;

    xcvr_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (ctrl.strobe),
        .rise  (rise)
    );

    assign op = pick_op(ctrl.pass, rise);

    xcvr_store #(.WIDTH(WIDTH)) u_store (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .din  (src),
        .dout (stored)
    );

    assign oe = drive_active(ctrl.drive, OE_ACTIVE_LOW);

    xcvr_oe_drive #(.WIDTH(WIDTH)) u_drive (
        .en  (oe),
        .val (stored),
        .pad (dst)
    );
endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = XCVR_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ab_pass,
    input  logic             ab_strobe,
    input  logic             ab_drive,
    input  logic             ba_pass,
    input  logic             ba_strobe,
    input  logic             ba_drive_n,
    inout  wire  [WIDTH-1:0] port_a,
    inout  wire  [WIDTH-1:0] port_b
);
    lane_ctrl_t ctrl_ab;
    lane_ctrl_t ctrl_ba;

    assign ctrl_ab = '{pass: ab_pass, strobe: ab_strobe, drive: ab_drive};
    assign ctrl_ba = '{pass: ba_pass, strobe: ba_strobe, drive: ba_drive_n};

    xcvr_lane #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b0)) u_lane_ab (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl_ab),
        .src  (port_a),
        .dst  (port_b)
    );

    xcvr_lane #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b1)) u_lane_ba (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl_ba),
        .src  (port_b),
        .dst  (port_a)
    );
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int unsigned WIDTH = 18
) (
    input logic             clk,
    input logic             rst,
    input logic             ab_pass,
    input logic             ab_strobe,
    input logic             ab_drive,
    input logic             ba_pass,
    input logic             ba_strobe,
    input logic             ba_drive_n,
    input logic [WIDTH-1:0] port_a,
    input logic [WIDTH-1:0] port_b
);
    // R1: transparent A-to-B path
    assert_pass_ab_R1: assert property (@(posedge clk) disable iff (rst)
        (ab_pass && ab_drive) |-> (port_b == port_a));

    // R5: transparent B-to-A path (R6: enabled by low level)
    assert_pass_ba_R5: assert property (@(posedge clk) disable iff (rst)
        (ba_pass && !ba_drive_n) |-> (port_a == port_b));

    // R2: a rise with pass low loads the source value seen at that edge
    assert_capture_ab_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !$past(ab_pass) && !ab_pass && ab_drive
         && $past(ab_strobe) && !$past(ab_strobe, 2))
        |-> (port_b == $past(port_a)));

    // R3: without a rise, the stored A-to-B value stays put
    assert_hold_ab_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ab_pass) && !ab_pass && ab_drive && $past(ab_drive)
         && !($past(ab_strobe) && !$past(ab_strobe, 2)))
        |-> $stable(port_b));

    // R5: without a rise, the stored B-to-A value stays put
    assert_hold_ba_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ba_pass) && !ba_pass && !ba_drive_n && !$past(ba_drive_n)
         && !($past(ba_strobe) && !$past(ba_strobe, 2)))
        |-> $stable(port_a));

    // R9: storage reads zero on the cycle after reset
    assert_reset_zero_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && ab_drive && !ab_pass) |-> (port_b == '0));
endmodule

bind dual_path_xcvr xcvr_checker #(.WIDTH(WIDTH)) u_checker (
    .clk        (clk),
    .rst        (rst),
    .ab_pass    (ab_pass),
    .ab_strobe  (ab_strobe),
    .ab_drive   (ab_drive),
    .ba_pass    (ba_pass),
    .ba_strobe  (ba_strobe),
    .ba_drive_n (ba_drive_n),
    .port_a     (port_a),
    .port_b     (port_b)
);

// File: tb/tb_dual_path_xcvr.sv
`timescale 1ns/1ps
module tb_dual_path_xcvr;
    localparam int W = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ab_pass = 0, ab_strobe = 0, ab_drive = 0;
    logic ba_pass = 0, ba_strobe = 0, ba_drive_n = 1;
    logic [W-1:0] tb_a = '0, tb_b = '0;
    logic tb_a_en = 0, tb_b_en = 0;
    wire  [W-1:0] port_a;
    wire  [W-1:0] port_b;
    int total = 0;
    int bad = 0;

    assign port_a = tb_a_en ? tb_a : {W{1'bz}};
    assign port_b = tb_b_en ? tb_b : {W{1'bz}};

    always #5 clk = ~clk;

    dual_path_xcvr dut (
        .clk(clk), .rst(rst),
        .ab_pass(ab_pass), .ab_strobe(ab_strobe), .ab_drive(ab_drive),
        .ba_pass(ba_pass), .ba_strobe(ba_strobe), .ba_drive_n(ba_drive_n),
        .port_a(port_a), .port_b(port_b)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        ab_drive = 1; step();
        check("R9 B after reset", port_b, '0);
        ab_drive = 0; ba_drive_n = 0; #1;
        check("R9 A after reset", port_a, '0);
        ba_drive_n = 1;
        check("R10 width", W'($bits(port_a)), W'(18));
    endtask

    task automatic t_pass_ab();
        logic [W-1:0] pats [4] = '{18'h3FFFF, 18'h00001, 18'h2AAAA, 18'h15555};
        tb_a_en = 1; ab_pass = 1; ab_drive = 1;
        foreach (pats[i]) begin
            tb_a = pats[i]; #1;
            check("R1 transparent", port_b, pats[i]);
            step();
        end
    endtask

    task automatic t_close_ab();
        tb_a = 18'h1234A; step();
        ab_pass = 0; step();
        tb_a = 18'h0F0F0; step();
        check("R7 keep on close", port_b, 18'h1234A);
    endtask

    task automatic t_capture_ab();
        ab_strobe = 0; tb_a = 18'h00C3C; step();
        ab_strobe = 1; step();
        check("R2 rise load", port_b, 18'h00C3C);
        tb_a = 18'h3E001; step();
        check("R3 strobe high", port_b, 18'h00C3C);
        ab_strobe = 0; step();
        check("R3 strobe fall", port_b, 18'h00C3C);
        step();
        check("R3 strobe low", port_b, 18'h00C3C);
        ab_strobe = 1; step();
        check("R2 second rise", port_b, 18'h3E001);
        // rise together with pass falling: load wins, no leak afterwards
        ab_strobe = 0; ab_pass = 1; tb_a = 18'h11111; step();
        ab_pass = 0; ab_strobe = 1; tb_a = 18'h22222; step();
        tb_a = 18'h33333; step();
        check("R2 rise at close", port_b, 18'h22222);
        ab_strobe = 0;
    endtask

    task automatic t_hiz_ab();
        ab_drive = 0; tb_b_en = 1; tb_b = 18'h2D2D2; #1;
        check("R4 B released", port_b, 18'h2D2D2);
        tb_b_en = 0; ab_drive = 1; #1;
        check("R4 B driven", port_b, 18'h22222);
        step();
    endtask

    task automatic t_ba();
        ab_drive = 0; tb_a_en = 0; tb_b_en = 1;
        ba_pass = 1; ba_drive_n = 0; tb_b = 18'h0ABCD; #1;
        check("R5 transparent", port_a, 18'h0ABCD);
        step();
        ba_drive_n = 1; tb_a_en = 1; tb_a = 18'h35353; #1;
        check("R6 A released", port_a, 18'h35353);
        tb_a_en = 0; ba_drive_n = 0; #1;
        check("R6 A driven", port_a, 18'h0ABCD);
        ba_pass = 0; step();
        tb_b = 18'h00777; step();
        check("R7 BA keep", port_a, 18'h0ABCD);
        ba_strobe = 1; step();
        check("R5 BA rise load", port_a, 18'h00777);
        tb_b = 18'h3FF00; ba_strobe = 0; step();
        check("R5 BA fall", port_a, 18'h00777);
        ba_drive_n = 1;
    endtask

    task automatic t_independent();
        tb_b_en = 0; tb_a_en = 1; tb_a = 18'h1C1C1; ab_strobe = 1; step();
        ab_strobe = 0; tb_a_en = 0; tb_b_en = 1; tb_b = 18'h02468; ba_strobe = 1; step();
        ba_strobe = 0; tb_b_en = 0; ab_drive = 1; ba_drive_n = 0; step();
        check("R8 B from AB", port_b, 18'h1C1C1);
        check("R8 A from BA", port_a, 18'h02468);
        ab_drive = 0; ba_drive_n = 1;
    endtask

    task automatic t_reset_armed();
        ab_strobe = 1; rst = 1; step(); step();
        tb_a_en = 1; tb_a = 18'h3ABCD; rst = 0; step();
        ab_drive = 1; #1;
        check("R9 high strobe no load", port_b, '0);
        step();
        check("R9 still zero", port_b, '0);
    endtask

    initial begin
        repeat (3) step();
        rst = 0;
        t_reset();
        t_pass_ab();
        t_close_ab();
        t_capture_ab();
        t_hiz_ab();
        t_ba();
        t_independent();
        t_reset_armed();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule